// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two W-bit two's-complement numbers over W clock cycles and returns their full 2W-bit signed product. It uses radix-2 Booth recoding. Each cycle it looks at the lowest bit of the remaining multiplier and the bit that was shifted out before it. It then subtracts the multiplicand from the upper accumulator when a run of ones starts, adds it back just past the end of a run, and leaves the accumulator alone otherwise. After that the whole working register shifts right by one place, and the shift copies the sign bit. Signed operands therefore need no conversion to magnitude first, and no correction afterwards.

A caller pulses `start_i` with both operands while the block is idle. The block raises `busy_o` until the result is ready, then raises `done_o` for a single cycle. From that cycle until the next accepted start, `product_o` holds the result. Start pulses that arrive while the block is busy are dropped.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A `start_i` sampled high while `busy_o` is low loads both operands, and `busy_o` is 1 from the next cycle. `busy_o` is 0 in the cycle where `done_o` is 1.
- R3: If a start is accepted at clock edge k, `done_o` is 1 only between edge k+W and edge k+W+1. It is a single-cycle pulse.
- R4: When `done_o` is 1, `product_o` equals the signed product of the loaded operands, as a 2W-bit two's-complement value (bit 2W-1 is the sign).
- R5: While `busy_o` is low and no start is accepted, `product_o` keeps the last result, or zero if there has been none since reset.
- R6: A `start_i` pulse, and any operand values, presented while `busy_o` is high change neither the result nor the timing of the operation in progress.
- R7: With W = 4, multiplicand 0010 times multiplier 0111 gives 0000_1110, and 0010 times 1101 gives 1111_1010.
- R8: Operands at the most negative value are exact. The most negative value times itself gives 2^(2W-2), and the most negative value times -1 gives +2^(W-1).
- R9: A start accepted in the cycle in which `done_o` is 1 begins a new operation with the usual timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a multiply; taken only when idle |
| mcand_i | input | W | Signed multiplicand |
| mplier_i | input | W | Signed multiplier |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse: result valid |
| product_o | output | 2W | Signed 2W-bit product |

## Verification
The bench runs all 256 operand pairs at W = 4 and random pairs at W = 32. It also aims at the most negative value as multiplicand and as multiplier.
- A design whose accumulator is only W bits wide gives the wrong sign when it subtracts the most negative multiplicand. The R8 and exhaustive results catch this.
- A logical shift in place of an arithmetic one corrupts every negative product.
- The bench injects start pulses while the block is busy. A design that reloads or restarts on such a pulse returns the wrong product or raises done late.
- Back-to-back starts accepted in the done cycle expose a controller that needs an extra idle cycle.

// File: rtl/booth_pkg.sv
package booth_pkg;

    // Arithmetic step chosen from the (current, previous) multiplier bit pair
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_ADD  = 2'd1,
        STEP_SUB  = 2'd2
    } step_e;

    // Decode one recoding pair: 10 starts a run of ones, 01 closes one
    function automatic step_e pair_to_step(input logic [1:0] pair);
        case (pair)
            2'b10:   return STEP_SUB;
            2'b01:   return STEP_ADD;
            default: return STEP_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic [1:0] pair_i,
    output step_e      step_o
);

    always_comb begin
        step_o = pair_to_step(pair_i);
    end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int AW = 33
) (
    input  logic [AW-1:0] acc_i,
    input  logic [AW-1:0] addend_i,
    input  step_e         step_i,
    output logic [AW-1:0] acc_o
);

    logic [AW-1:0] operand;
    logic          carry_in;

    // Subtraction as acc + ~m + 1: one adder for both directions
    always_comb begin
        operand  = '0;
        carry_in = 1'b0;
        case (step_i)
            STEP_ADD: begin
                operand  = addend_i;
                carry_in = 1'b0;
            end
            STEP_SUB: begin
                operand  = ~addend_i;
                carry_in = 1'b1;
            end
            default: begin
                operand  = '0;
                carry_in = 1'b0;
            end
        endcase
        acc_o = acc_i + operand + AW'(carry_in);
    end

endmodule

// File: rtl/booth_ashr.sv
module booth_ashr #(
    parameter int PW = 66
) (
    input  logic [PW-1:0] word_i,
    output logic [PW-1:0] word_o
);

    // Shift right by one place; the top bit is copied to keep the sign
    always_comb begin
        word_o = {word_i[PW-1], word_i[PW-1:1]};
    end

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
    import booth_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [W-1:0]   mcand_i,
    input  logic [W-1:0]   mplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*W-1:0] product_o
);

    // Working register: guard-extended accumulator | multiplier | shifted-out bit
    localparam int AW = W + 1;
    localparam int PW = AW + W + 1;
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  mcand;
        logic [PW-1:0] work;
    } state_t;

    state_t st_q, st_d;

    step_e         step;
    logic [AW-1:0] acc_cur;
    logic [AW-1:0] acc_new;
    logic [AW-1:0] mcand_ext;
    logic [PW-1:0] work_pre;
    logic [PW-1:0] work_shift;

    assign acc_cur   = st_q.work[PW-1 -: AW];
    assign mcand_ext = {st_q.mcand[W-1], st_q.mcand};

    booth_recode u_recode (
        .pair_i (st_q.work[1:0]),
        .step_o (step)
    );

    booth_addsub #(.AW(AW)) u_addsub (
        .acc_i    (acc_cur),
        .addend_i (mcand_ext),
        .step_i   (step),
        .acc_o    (acc_new)
    );

    assign work_pre = {acc_new, st_q.work[W:0]};

    booth_ashr #(.PW(PW)) u_ashr (
        .word_i (work_pre),
        .word_o (work_shift)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.cnt   = '0;
                st_d.mcand = mcand_i;
                st_d.work  = {{AW{1'b0}}, mplier_i, 1'b0};
            end
        end else begin
            st_d.work = work_shift;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = st_q.busy;
    assign done_o    = st_q.done;
    assign product_o = st_q.work[2*W:1];

endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*W-1:0] product_o
);

    logic [31:0] since_accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_accept <= '0;
        end else if (start_i && !busy_o) begin
            since_accept <= '0;
        end else if (busy_o) begin
            since_accept <= since_accept + 32'd1;
        end
    end

    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);                                  // R2
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                               // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                               // R3
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (since_accept == 32'(W)));                              // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(product_o));                     // R5

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/test_booth_seq_mul.sv
module mul_harness #(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_err,
    output logic fin
);

    logic           start;
    logic [W-1:0]   a, b;
    logic           busy, done;
    logic [2*W-1:0] prod;

    booth_seq_mul #(.W(W)) i_booth_seq_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .mcand_i   (a),
        .mplier_i  (b),
        .busy_o    (busy),
        .done_o    (done),
        .product_o (prod)
    );

    // Behavioural reference, advanced on each rising edge
    logic           m_busy, m_done, m_inj;
    int             m_cnt;
    logic [2*W-1:0] m_pend, m_res;
    string          tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0; m_inj <= 1'b0;
            m_pend <= '0;   m_res  <= '0;
        end else begin
            m_done <= 1'b0;
            if (!m_busy) begin
                if (start) begin
                    m_busy <= 1'b1; m_cnt <= 0; m_inj <= 1'b0;
                    m_pend <= $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
                end
            end else begin
                if (start) m_inj <= 1'b1;
                m_cnt <= m_cnt + 1;
                if (m_cnt + 1 == W) begin
                    m_busy <= 1'b0; m_done <= 1'b1; m_res <= m_pend;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s W=%0d: actual=%h expected=%h", req, W, act, exp);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", (2*W)'(busy), (2*W)'(m_busy));
            chk((m_cnt == W - 1 || m_done) && m_inj ? "R6" : "R3", (2*W)'(done), (2*W)'(m_done));
            if (m_done) chk(m_inj ? "R6" : tag, prod, m_res);
            else if (!m_busy) chk("R5", prod, m_res);
        end
    end

    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input bit inject);
        @(negedge clk);
        start = 1'b1; a = x; b = y;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            start = 1'b1; a = W'($urandom); b = W'($urandom);
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    initial begin
        n_chk = 0; n_err = 0; fin = 1'b0; tag = "R4";
        start = 1'b0; a = '0; b = '0;
        @(posedge rst_n);
        @(negedge clk);
        chk("R1", {busy, done, {(2*W-2){1'b0}}}, '0);
        chk("R1", prod, '0);

        if (W == 4) begin
            tag = "R7";
            run_op(W'(2), W'(7), 1'b0);
            chk("R7", prod, (2*W)'(8'h0E));
            run_op(W'(2), W'(13), 1'b0);
            chk("R7", prod, (2*W)'(8'hFA));
            tag = "R4";
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    run_op(W'(i), W'(j), ((i + j) % 7) == 0);
                end
            end
        end else begin
            for (int k = 0; k < 150; k++) begin
                run_op(W'($urandom), W'($urandom), (k % 5) == 0);
            end
        end

        tag = "R8";
        run_op(MINV, MINV, 1'b0);
        chk("R8", prod, (2*W)'(1) << (2*W - 2));
        run_op(MINV, '1, 1'b0);
        chk("R8", prod, (2*W)'(1) << (W - 1));
        run_op(MINV, W'(3), 1'b1);
        run_op(W'(5), MINV, 1'b0);

        // Start accepted in the done cycle: next op back to back
        tag = "R9";
        @(negedge clk);
        start = 1'b1; a = W'(3); b = W'(-2);
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        start = 1'b1; a = W'(-1); b = W'(-1);
        @(negedge clk);
        start = 1'b0;
        chk("R9", (2*W)'(busy), (2*W)'(1));
        while (!done) @(negedge clk);
        chk("R9", prod, (2*W)'(1));
        repeat (3) @(negedge clk);
        fin = 1'b1;
    end

endmodule

module test_booth_seq_mul;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   c4, e4, c32, e32;
    logic f4, f32;
    int   cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mul_harness #(.W(4))  u_h4  (.clk(clk), .rst_n(rst_n), .n_chk(c4),  .n_err(e4),  .fin(f4));
    mul_harness #(.W(32)) u_h32 (.clk(clk), .rst_n(rst_n), .n_chk(c32), .n_err(e32), .fin(f32));

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    end

    initial begin
        int tot;
        int err;
        while (!(f4 === 1'b1 && f32 === 1'b1) && cycles < MAX_CYCLES) begin
            @(posedge clk);
            cycles++;
        end
        tot = c4 + c32;
        err = e4 + e32;
        if (cycles >= MAX_CYCLES) begin
            tot++;
            err++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
        end
        $display("Result: errors=%0d of %0d checks", err, tot);
        $finish;
    end

endmodule